// File: doc/BRIEF.md
# Sector Bit-Flip Corrector

This block takes the outcome of a BCH decode for one sector (an error-found flag, an uncorrectable flag and an error count) together with up to eight bit positions. It then repairs the sector in a byte-wide on-chip RAM by inverting the bits at those positions. The syndrome and root search happen upstream. This block only applies their result.

A `start` pulse captures all inputs. The block checks the flags, then walks the positions in order. It skips any position that points past the data area, for example into the parity bytes stored behind the sector. Each valid position becomes a read of the addressed byte, followed in the next cycle by a write of that byte with one bit inverted. When the work is finished, a one-cycle `done` pulse reports a two-bit result, which stays valid until the next start.

Top module: `ecc_bitflip_fixer`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low. No RAM access occurs while `busy` is low.
- R2: A `start` while idle captures the flags, the count and `pos_words`. `busy` stays high from the next cycle through the cycle in which `done` is high, and `done` lasts exactly one cycle.
- R3: If `stat_found` is 0, no byte is written and `result` is 2'b00, whatever `stat_uncorr` and `stat_count` hold.
- R4: If `stat_found` is 1 and `stat_uncorr` is 1, no byte is written and `result` is 2'b10.
- R5: If `stat_found` is 1 and `stat_uncorr` is 0, then for each of the first N positions, bit (p mod 8) of byte (p / 8) is inverted, and `result` is 2'b01. N is the effective count, and N = 0 is allowed. Position i is the 16-bit field `pos_words[16*i +: 16]`, so a 32-bit word holds two positions, the first in bits 12:0 and the second in bits 28:16.
- R6: A position field whose value is at least `SECTOR_BYTES*8` (4096 by default) is skipped with no RAM access. This includes any field with a nonzero bit among 15:13.
- R7: A `stat_count` above eight is treated as eight.
- R8: Positions are applied strictly in order, each as a read followed next cycle by a write to the same byte. A repeated position therefore restores the bit.
- R9: Counted from the clock edge that samples `start`, `done` is seen after 1 edge when no correction is made. On the correcting path it is seen after 2 + 2k + m edges, where k is the number of applied flips and m the number of skipped positions.
- R10: `start` and input changes while `busy` is high have no effect on the sector or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one sector, captured when idle |
| stat_uncorr | input | 1 | Decoder found too many errors |
| stat_found | input | 1 | Decoder found at least one error |
| stat_count | input | 4 | Number of reported positions |
| pos_words | input | 16*MAX_FIX | Packed positions, 16-bit field each, value in bits 12:0 |
| busy | output | 1 | Work in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| mem_rd | output | 1 | RAM read strobe, data one cycle later |
| mem_wr | output | 1 | RAM write strobe |
| mem_addr | output | $clog2(SECTOR_BYTES) | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid the cycle after `mem_rd` |

## Verification
The in-module assertions watch the RAM handshake and the control shape on every cycle. Each write must follow a read of the same byte. There must be no access while idle. A start must raise `busy`, and `done` must last one cycle. Only the bench scenarios can show that the right bits changed and nothing else did. The same holds for the flag decisions, the skipping of out-of-range positions, count clamping, cancelling of repeated positions, the exact completion latency and the immunity to stray starts.

// File: rtl/ecc_bitflip_fixer.sv
module ecc_bitflip_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_FIX      = 8,
  localparam int AW = $clog2(SECTOR_BYTES),
  localparam int IW = $clog2(MAX_FIX + 1),
  localparam int SW = $clog2(MAX_FIX),
  localparam int PW = 16 * MAX_FIX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stat_uncorr,
  input  logic          stat_found,
  input  logic [3:0]    stat_count,
  input  logic [PW-1:0] pos_words,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);

  localparam logic [15:0] LIMIT = 16'(SECTOR_BYTES * 8);
  localparam logic [1:0]  RES_CLEAN = 2'b00, RES_FIXED = 2'b01, RES_BAD = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_SCAN, S_FIX, S_FIN} st_t;

  st_t           st;
  logic          fnd_q, unc_q;
  logic [IW-1:0] cnt_q, idx;
  logic [PW-1:0] pos_q;
  logic [1:0]    res_q;
  logic [15:0]   cur;
  logic          more, in_rng;

  assign cur    = pos_q[16 * int'(idx[SW-1:0]) +: 16];
  assign more   = idx < cnt_q;
  assign in_rng = cur < LIMIT;

  assign busy      = st != S_IDLE;
  assign done      = st == S_FIN;
  assign result    = res_q;
  assign mem_rd    = (st == S_SCAN) && more && in_rng;
  assign mem_wr    = st == S_FIX;
  assign mem_addr  = cur[3 +: AW];
  assign mem_wdata = mem_rdata ^ (8'd1 << cur[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      fnd_q <= 1'b0;
      unc_q <= 1'b0;
      cnt_q <= '0;
      idx   <= '0;
      pos_q <= '0;
      res_q <= RES_CLEAN;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          fnd_q <= stat_found;
          unc_q <= stat_uncorr;
          cnt_q <= (int'(stat_count) > MAX_FIX) ? IW'(MAX_FIX) : IW'(stat_count);
          pos_q <= pos_words;
          idx   <= '0;
          st    <= S_CHK;
        end
        S_CHK: begin
          if (!fnd_q) begin
            res_q <= RES_CLEAN;
            st    <= S_FIN;
          end else if (unc_q) begin
            res_q <= RES_BAD;
            st    <= S_FIN;
          end else begin
            st <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (!more) begin
            res_q <= RES_FIXED;
            st    <= S_FIN;
          end else if (!in_rng) begin
            idx <= idx + IW'(1);
          end else begin
            st <= S_FIX;
          end
        end
        S_FIX: begin
          idx <= idx + IW'(1);
          st  <= S_SCAN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R8
  AST_WR_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R1

endmodule

// File: tb/test_ecc_bitflip_fixer.sv
module test_ecc_bitflip_fixer;
  localparam int SB = 512;
  localparam int NF = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic s_unc = 1'b0, s_fnd = 1'b0;
  logic [3:0] s_cnt = '0;
  logic [16*NF-1:0] pw = '0;
  logic busy, done, mem_rd, mem_wr;
  logic [1:0] result;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] ram [SB];
  logic [7:0] gold [SB];
  int total = 0, bad = 0, wr_cnt = 0;

  always #5 clk = ~clk;

  ecc_bitflip_fixer #(.SECTOR_BYTES(SB), .MAX_FIX(NF)) i_ecc_bitflip_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .stat_uncorr(s_unc),
    .stat_found(s_fnd), .stat_count(s_cnt), .pos_words(pw), .busy(busy),
    .done(done), .result(result), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always_ff @(posedge clk) begin
    if (mem_wr) begin
      ram[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic unc, input logic fnd, input logic [3:0] cnt,
                     input logic [16*NF-1:0] p);
    int n, k, m, e, w0, diff;
    logic [1:0] xres;
    logic [15:0] f;
    for (int i = 0; i < SB; i++) gold[i] = ram[i];
    k = 0; m = 0;
    n = (int'(cnt) > NF) ? NF : int'(cnt);
    if (!fnd) xres = 2'b00;
    else if (unc) xres = 2'b10;
    else begin
      xres = 2'b01;
      for (int i = 0; i < n; i++) begin
        f = p[16*i +: 16];
        if (f < 16'(SB*8)) begin
          gold[f >> 3] = gold[f >> 3] ^ (8'd1 << f[2:0]);
          k++;
        end else m++;
      end
    end
    w0 = wr_cnt;
    @(negedge clk);
    s_unc = unc; s_fnd = fnd; s_cnt = cnt; pw = p; start = 1'b1;
    @(posedge clk);
    e = 0;
    @(negedge clk);
    s_unc = ~unc; s_fnd = ~fnd; s_cnt = 4'hf; pw = ~p;
    start = busy;
    while (!done && e < 300) begin
      @(posedge clk); e++;
      @(negedge clk); start = 1'b0;
    end
    chk("R9 latency", e, (fnd && !unc) ? 2 + 2*k + m : 1);
    chk("R3/R4/R5 result", int'(result), int'(xres));
    @(negedge clk);
    chk("R2 done one cycle, busy drops", int'({done, busy}), 0);
    chk("R10 result held", int'(result), int'(xres));
    diff = 0;
    for (int i = 0; i < SB; i++) if (ram[i] != gold[i]) diff++;
    chk("R5/R6/R7/R8/R10 sector bytes differing", diff, 0);
    chk("R3/R4/R8 write count", wr_cnt - w0, k);
  endtask

  function automatic logic [16*NF-1:0] pk(input int a0, a1, a2, a3, a4, a5, a6, a7);
    return {16'(a7), 16'(a6), 16'(a5), 16'(a4), 16'(a3), 16'(a2), 16'(a1), 16'(a0)};
  endfunction

  task automatic t_reset;
    chk("R1 reset outputs", int'({busy, done, mem_rd, mem_wr}), 0);
  endtask
  task automatic t_clean;
    run(1'b0, 1'b0, 4'd0, pk(1, 2, 3, 4, 5, 6, 7, 8));
    run(1'b1, 1'b0, 4'd3, pk(10, 20, 30, 0, 0, 0, 0, 0));   // R3 unc without found
  endtask
  task automatic t_uncorr;
    run(1'b1, 1'b1, 4'd3, pk(10, 20, 30, 0, 0, 0, 0, 0));   // R4
  endtask
  task automatic t_fix;
    run(1'b0, 1'b1, 4'd4, pk(0, 77, 1234, 4000, 9, 9, 9, 9)); // R5 only first four
    run(1'b0, 1'b1, 4'd0, pk(5, 6, 7, 8, 0, 0, 0, 0));        // R5 zero count
  endtask
  task automatic t_range;
    run(1'b0, 1'b1, 4'd5, pk(4095, 4096, 8191, 16'hE001, 100, 0, 0, 0)); // R6
  endtask
  task automatic t_clamp;
    run(1'b0, 1'b1, 4'd12, pk(1, 300, 601, 902, 1203, 1504, 1805, 2106)); // R7
  endtask
  task automatic t_order;
    run(1'b0, 1'b1, 4'd6, pk(40, 40, 41, 42, 43, 40, 0, 0)); // R8
  endtask

  initial begin
    for (int i = 0; i < SB; i++) ram[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_uncorr();
    t_fix();
    t_range();
    t_clamp();
    t_order();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule